// File: doc/BRIEF.md
# Down-Counting Timer Channel with Dual Match

This block is a single timer channel whose count register counts downward. Each step happens either on every system clock or only when an externally generated 1 MHz tick strobe is high. A four-bit control vector selects the source and turns on the channel, the overflow interrupt and the pulse output. The control vector is held by a register block outside this channel, and that block also performs any set/clear register handling.

Software loads four values through a simple write port: the count, a reload value and two compare values. When the count has already reached zero, the next step reloads it from the reload value. A step that takes the count from one to zero can raise a sticky interrupt flag. A step that lands on either compare value gives a one-cycle match strobe, and that strobe can also toggle a pulse output. The current count is always visible at an output port.

Top module: `dtimer_chan`

## Requirements
- R1: While reset is asserted, count_o, irq_o, match_o and pulse_o are 0. The reload value and both compare values are also 0.
- R2: The control bits are: ctrl_i[0] run, ctrl_i[1] source, ctrl_i[2] interrupt enable and ctrl_i[3] pulse enable. With run=1 and source=0, a non-zero count drops by one on every clock edge.
- R3: With run=1 and source=1, the count steps only on clock edges where tick_1m_i is 1. On all other edges it holds.
- R4: A step taken while the count is 0 loads the reload value in place of decrementing.
- R5: A write with wr_en_i=1 stores wr_data_i at the next edge. wr_sel_i selects the target: 0 count, 1 reload, 2 first compare, 3 second compare. A count write takes priority over any step in the same cycle.
- R6: If run rises from 0 to 1 while the count is 0, the count loads the reload value at that edge, and no step is taken in that cycle.
- R7: A step from 1 to 0 with interrupt enable set raises irq_o at the same edge as the count becomes 0.
- R8: irq_o stays set until a cycle with irq_clr_i=1 clears it. If a set and a clear fall in the same cycle, the set wins.
- R9: match_o is 1 for exactly the cycle after a step whose new count equals either compare value. The compare uses the compare values held before that edge.
- R10: With pulse enable set, pulse_o toggles at the same edge at which match_o rises. Otherwise pulse_o holds.
- R11: With run=0, the count changes only through writes. No match strobe is produced and irq_o is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 4 | Run, source select, interrupt enable, pulse enable |
| tick_1m_i | input | 1 | External 1 MHz tick strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target select |
| wr_data_i | input | CW | Write data |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| count_o | output | CW | Current count |
| irq_o | output | 1 | Sticky overflow interrupt flag |
| match_o | output | 1 | One-cycle compare match strobe |
| pulse_o | output | 1 | Toggling pulse output |

## Verification
The hardest cases to reach are collisions within one cycle. These include a 1-to-0 step that meets an interrupt clear, and a run rising edge with a zero count that arrives together with a tick or a count write. In these cases the ordering rules alone decide the result. Directed phases set up small reload and compare values, so that wraps and matches recur every few cycles. A long pseudo-random phase then toggles control bits, ticks, clears and writes over a range of 0 to 15, which makes these collisions frequent. A behavioural model checks every clock.

// File: rtl/dtimer_chan.sv
module dtimer_chan #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    ctrl_i,
  input  logic          tick_1m_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          irq_clr_i,
  output logic [CW-1:0] count_o,
  output logic          irq_o,
  output logic          match_o,
  output logic          pulse_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q, rel_q, m1_q, m2_q, cnt_d;
  logic          en_q, irq_q, pulse_q, hit_q;

  wire run    = ctrl_i[0];
  wire adv    = run & (ctrl_i[1] ? tick_1m_i : 1'b1);
  wire cnt_wr = wr_en_i & (wr_sel_i == 2'd0);
  wire is0    = (cnt_q == '0);
  wire arm    = run & ~en_q & is0;
  wire step   = adv & ~cnt_wr & ~arm;
  wire hit    = step & ((cnt_d == m1_q) | (cnt_d == m2_q));
  wire reach  = step & ctrl_i[2] & (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)    cnt_d = wr_data_i;
    else if (arm)  cnt_d = rel_q;
    else if (adv)  cnt_d = is0 ? rel_q : cnt_q - ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rel_q   <= '0;
      m1_q    <= '0;
      m2_q    <= '0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      pulse_q <= 1'b0;
      hit_q   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= run;
      hit_q <= hit;
      if (wr_en_i && wr_sel_i == 2'd1) rel_q <= wr_data_i;
      if (wr_en_i && wr_sel_i == 2'd2) m1_q  <= wr_data_i;
      if (wr_en_i && wr_sel_i == 2'd3) m2_q  <= wr_data_i;
      if (reach)          irq_q <= 1'b1;
      else if (irq_clr_i) irq_q <= 1'b0;
      if (hit && ctrl_i[3]) pulse_q <= ~pulse_q;
    end
  end

  assign count_o = cnt_q;
  assign irq_o   = irq_q;
  assign match_o = hit_q;
  assign pulse_o = pulse_q;

  assert_pclk_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[0] && !ctrl_i[1] && !cnt_wr && en_q && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

  assert_tick_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[1] && !tick_1m_i && !cnt_wr && en_q) |=> $stable(cnt_q));

  assert_irq_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> cnt_q == '0);

  assert_irq_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);

  assert_match_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_q |-> (cnt_q == $past(m1_q)) || (cnt_q == $past(m2_q)));

  assert_pulse_on_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pulse_q) |-> hit_q);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i[0] && !cnt_wr) |=> $stable(cnt_q) && !hit_q);

endmodule

// File: tb/sim_dtimer_chan.sv
module sim_dtimer_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ctrl = '0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        clr = 1'b0;
  logic [31:0] count;
  logic        irq, match, pulse;

  dtimer_chan #(.CW(32)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .tick_1m_i(tick),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data), .irq_clr_i(clr),
    .count_o(count), .irq_o(irq), .match_o(match), .pulse_o(pulse)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0, live = 0;
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  logic [31:0] e_cnt = 0, e_rel = 0, e_m1 = 0, e_m2 = 0;
  bit e_irq = 0, e_pulse = 0, e_match = 0, e_prev_run = 0;
  string why = "R1", irq_why = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_cnt = 0; e_rel = 0; e_m1 = 0; e_m2 = 0;
      e_irq = 0; e_pulse = 0; e_match = 0; e_prev_run = 0;
      why = "R1"; irq_why = "R8";
    end else begin
      bit stepped, hit_now, set_irq;
      stepped = 0; hit_now = 0; set_irq = 0;
      if (wr_en && wr_sel == 0) begin
        e_cnt = wr_data; why = "R5";
      end else if (ctrl[0] && !e_prev_run && e_cnt == 0) begin
        e_cnt = e_rel; why = "R6";
      end else if (ctrl[0] && (!ctrl[1] || tick)) begin
        stepped = 1;
        if (e_cnt == 0) begin
          e_cnt = e_rel; why = "R4";
        end else begin
          if (e_cnt == 1 && ctrl[2]) set_irq = 1;
          e_cnt = e_cnt - 1;
          why = ctrl[1] ? "R3" : "R2";
        end
      end else begin
        why = ctrl[0] ? "R3" : "R11";
      end
      if (stepped && (e_cnt == e_m1 || e_cnt == e_m2)) hit_now = 1;
      if (wr_en && wr_sel == 1) e_rel = wr_data;
      if (wr_en && wr_sel == 2) e_m1 = wr_data;
      if (wr_en && wr_sel == 3) e_m2 = wr_data;
      if (set_irq) begin e_irq = 1; irq_why = "R7"; end
      else if (clr) begin e_irq = 0; irq_why = "R8"; end
      else irq_why = ctrl[0] ? "R8" : "R11";
      if (hit_now && ctrl[3]) e_pulse = !e_pulse;
      e_match = hit_now;
      e_prev_run = ctrl[0];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_n) begin
      chk(why, count, e_cnt);
      chk(irq_why, {31'b0, irq}, {31'b0, e_irq});
      chk("R9", {31'b0, match}, {31'b0, e_match});
      chk("R10", {31'b0, pulse}, {31'b0, e_pulse});
    end
  end

  task automatic cyc(input logic [3:0] c, input bit t, input bit w,
                     input logic [1:0] s, input logic [31:0] d, input bit cl);
    ctrl = c; tick = t; wr_en = w; wr_sel = s; wr_data = d; clr = cl;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] c, input logic [1:0] s, input logic [31:0] d);
    cyc(c, 0, 1, s, d, 0);
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", count, 0);
    chk("R1", {31'b0, irq}, 0);
    chk("R1", {31'b0, match}, 0);
    chk("R1", {31'b0, pulse}, 0);
    rst_n = 1'b1;
    live = 1;
    @(negedge clk);
    // idle with control cleared: nothing moves (R11)
    repeat (4) cyc(4'h0, 1, 0, 0, 0, 0);
    wr(4'h0, 2'd1, 32'd10);
    wr(4'h0, 2'd2, 32'd7);
    wr(4'h0, 2'd3, 32'd3);
    wr(4'h0, 2'd0, 32'd5);
    // system-clock stepping with interrupt and pulse (R2 R4 R7 R9 R10)
    repeat (30) cyc(4'hD, 0, 0, 0, 0, 0);
    cyc(4'hD, 0, 0, 0, 0, 1);
    // short reload, frequent clears to collide with sets (R8)
    wr(4'hD, 2'd1, 32'd2);
    for (int i = 0; i < 40; i++) cyc(4'hD, 0, 0, 0, 0, (i % 3) == 0);
    // 1 MHz tick source (R3)
    for (int i = 0; i < 120; i++) cyc(4'hF, (i % 5) == 4, 0, 0, 0, 0);
    // disable, zero the count, then enable: reload load (R6)
    repeat (5) cyc(4'h0, 1, 0, 0, 0, 0);
    wr(4'h0, 2'd1, 32'd9);
    wr(4'h0, 2'd0, 32'd0);
    repeat (12) cyc(4'hD, 0, 0, 0, 0, 0);
    // count write overriding a step (R5)
    wr(4'hD, 2'd0, 32'd100);
    repeat (4) cyc(4'hD, 0, 0, 0, 0, 0);
    // pseudo-random stress
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = rnd();
      if (r[3:0] == 0) ctrl = r[7:4];
      cyc(ctrl, r[9:8] == 0, r[13:10] < 2, r[15:14], {28'b0, r[19:16]}, r[22:20] == 0);
    end
    cyc(4'h0, 0, 0, 0, 0, 0);
    finish_run();
  end
endmodule